// File: doc/BRIEF.md
# Linked-List DMA Walker

This block is a DMA channel that follows a chain of packets in memory and sends each packet's payload to a peripheral. Each packet begins with a header word. The header's top byte gives the number of payload words that follow it. The header's low 24 bits point to the next packet. The engine reads the header through a word-read memory port. It then fetches the payload words one at a time and offers each one on a valid/ready stream. After the payload it follows the pointer to the next packet.

Software loads the start address into the channel's address register, then writes the start code to the control register. The walk can end in three ways. Normally it ends at a next pointer whose bit 23 is set. It also ends when a small loop guard sees a node revisited, or when a node-count limit is reached. At the end, the address register holds the stopping pointer, busy drops, a one-cycle interrupt pulse is raised, and a cause code records why the walk ended.

Top module: `llw_walker`

## Requirements
- R1: A walk starts only when the control register is written with 0x01000401 while idle. Any other control value is ignored: busy stays low and no memory read is issued.
- R2: A node address is the pointer ANDed with 0x1FFFFC. The header is read at the node address and payload word k (k from 0) at node address + 4(k+1), wrapping inside the 2 MiB space.
- R3: Header bits 31:24 are the payload word count and bits 23:0 are the next-node pointer.
- R4: Payload words leave on the stream in memory order. While valid is high and ready is low, valid stays high and the data holds.
- R5: A node whose count is zero sends no words and goes straight to its next pointer.
- R6: When a next pointer has bit 23 set, the walk ends with cause 0. The address register takes the full unmasked 24-bit pointer.
- R7: The loop guard keeps three addresses, all reset to all-ones at start: the last node, a lower slot and an upper slot. Before each node it checks whether the node matches the lower or upper slot. On a match the walk ends with cause 1 and the address register holds that node address; the node is not read. Otherwise, a node below the last one replaces the lower slot, any other node replaces the upper slot, and the node becomes the last one.
- R8: After NODE_LIMIT nodes have been visited, the next node is not read. The walk ends with cause 2 and the address register holds that node address. The limit check takes priority over the loop check.
- R9: At the end of a walk, busy falls and irq rises in the same cycle. irq stays high for exactly one cycle.
- R10: An address register write loads the register while idle. While busy the write is ignored.
- R11: Out of reset: busy, irq, cause, address register, memory request and stream valid are all zero. At most one memory read is outstanding, and a request lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 32 | Control write data; start code 0x01000401 |
| addr_wr_i | input | 1 | Address register write strobe |
| addr_wdata_i | input | 24 | Address register write data |
| addr_o | output | 24 | Address register: start pointer, then stopping pointer |
| busy_o | output | 1 | Walk in progress |
| irq_o | output | 1 | One-cycle completion pulse |
| end_cause_o | output | 2 | 0 terminator, 1 loop detected, 2 node limit |
| mem_req_o | output | 1 | One-cycle word read request |
| mem_addr_o | output | 21 | Byte address of requested word |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| out_valid_o | output | 1 | Payload word valid |
| out_data_o | output | 32 | Payload word |
| out_ready_i | input | 1 | Peripheral accepts payload word |

## Verification
The assertions assume the memory returns exactly one read-valid for each request, at least one cycle after it, and never returns one unprompted. They also assume software does not depend on a control write that arrives during a walk. The bench memory answers every request on the following cycle from a small array in the low kilobyte. All lists, including the looping one, the over-limit one and the ones with high-bit pointers, lie inside that array. The bench builds with a node limit of six, so the limit case stays short, and it varies stream readiness so that stalls occur on payload words.

// File: rtl/llw_pkg.sv
package llw_pkg;
  localparam logic [31:0] START_CODE = 32'h0100_0401;
  localparam int          TERM_BIT   = 23;
  localparam int          CNT_W      = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_HDR_REQ, S_HDR_WAIT, S_PAY_REQ, S_PAY_WAIT, S_PAY_OUT, S_NEXT
  } walk_state_e;

  typedef enum logic [1:0] {
    END_NORMAL = 2'd0,
    END_LOOP   = 2'd1,
    END_LIMIT  = 2'd2
  } end_cause_e;
endpackage

// File: rtl/llw_loop_guard.sv
module llw_loop_guard #(
  parameter int MEM_AW = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              visit_i,
  input  logic [MEM_AW-1:0] node_i,
  output logic              hit_o
);
  logic [MEM_AW-1:0] last_q, low_q, high_q;

  assign hit_o = (node_i == low_q) || (node_i == high_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '1;
      low_q  <= '1;
      high_q <= '1;
    end else if (clear_i) begin
      last_q <= '1;
      low_q  <= '1;
      high_q <= '1;
    end else if (visit_i) begin
      if (node_i < last_q) low_q <= node_i;
      else                 high_q <= node_i;
      last_q <= node_i;
    end
  end

  // R7: the walker never records a node that the guard flags
  p_no_visit_on_hit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    visit_i |-> !hit_o);
  // R7: a recorded node is caught if presented again next cycle
  p_visit_recorded_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (visit_i && !clear_i) |=> (($past(node_i) != node_i) || hit_o || clear_i));
endmodule

// File: rtl/llw_walk_fsm.sv
module llw_walk_fsm
  import llw_pkg::*;
#(
  parameter int AW         = 24,
  parameter int DW         = 32,
  parameter int MEM_AW     = 21,
  parameter int NODE_LIMIT = 2000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MEM_AW-1:0] start_node_i,
  output logic              mem_req_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              out_valid_o,
  output logic [DW-1:0]     out_data_o,
  input  logic              out_ready_i,
  input  logic              guard_hit_i,
  output logic              guard_visit_o,
  output logic              guard_clear_o,
  output logic [MEM_AW-1:0] guard_node_o,
  output logic              busy_o,
  output logic              done_o,
  output end_cause_e        done_cause_o,
  output logic [AW-1:0]     done_ptr_o
);
  localparam int CW = $clog2(NODE_LIMIT + 1);
  localparam logic [MEM_AW-1:0] NODE_MASK = {{(MEM_AW-2){1'b1}}, 2'b00};
  localparam logic [MEM_AW-1:0] WORD_STEP = MEM_AW'(4);

  walk_state_e       state_q, state_d;
  logic [MEM_AW-1:0] node_q, node_d;
  logic [MEM_AW-1:0] waddr_q, waddr_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [AW-1:0]     next_q, next_d;
  logic [DW-1:0]     data_q, data_d;
  logic [CW-1:0]     nodes_q, nodes_d;
  logic              at_limit;

  assign at_limit     = (nodes_q == CW'(NODE_LIMIT));
  assign busy_o       = (state_q != S_IDLE);
  assign mem_req_o    = (state_q == S_HDR_REQ) || (state_q == S_PAY_REQ);
  assign mem_addr_o   = (state_q == S_HDR_REQ) ? node_q : waddr_q;
  assign out_valid_o  = (state_q == S_PAY_OUT);
  assign out_data_o   = data_q;
  assign guard_node_o = node_q;
  assign guard_clear_o = (state_q == S_IDLE) && start_i;
  assign guard_visit_o = (state_q == S_CHECK) && !at_limit && !guard_hit_i;

  always_comb begin
    state_d      = state_q;
    node_d       = node_q;
    waddr_d      = waddr_q;
    left_d       = left_q;
    next_d       = next_q;
    data_d       = data_q;
    nodes_d      = nodes_q;
    done_o       = 1'b0;
    done_cause_o = END_NORMAL;
    done_ptr_o   = {{(AW-MEM_AW){1'b0}}, node_q};
    unique case (state_q)
      S_IDLE: if (start_i) begin
        node_d  = start_node_i & NODE_MASK;
        nodes_d = '0;
        state_d = S_CHECK;
      end
      S_CHECK: begin
        if (at_limit) begin
          done_o       = 1'b1;
          done_cause_o = END_LIMIT;
          state_d      = S_IDLE;
        end else if (guard_hit_i) begin
          done_o       = 1'b1;
          done_cause_o = END_LOOP;
          state_d      = S_IDLE;
        end else begin
          nodes_d = nodes_q + 1'b1;
          state_d = S_HDR_REQ;
        end
      end
      S_HDR_REQ: state_d = S_HDR_WAIT;
      S_HDR_WAIT: if (mem_rvalid_i) begin
        left_d  = mem_rdata_i[DW-1 -: CNT_W];
        next_d  = mem_rdata_i[AW-1:0];
        waddr_d = node_q + WORD_STEP;
        state_d = (mem_rdata_i[DW-1 -: CNT_W] == '0) ? S_NEXT : S_PAY_REQ;
      end
      S_PAY_REQ: state_d = S_PAY_WAIT;
      S_PAY_WAIT: if (mem_rvalid_i) begin
        data_d  = mem_rdata_i;
        state_d = S_PAY_OUT;
      end
      S_PAY_OUT: if (out_ready_i) begin
        left_d  = left_q - 1'b1;
        waddr_d = waddr_q + WORD_STEP;
        state_d = (left_q == CNT_W'(1)) ? S_NEXT : S_PAY_REQ;
      end
      S_NEXT: begin
        if (next_q[TERM_BIT]) begin
          done_o       = 1'b1;
          done_cause_o = END_NORMAL;
          done_ptr_o   = next_q;
          state_d      = S_IDLE;
        end else begin
          node_d  = next_q[MEM_AW-1:0] & NODE_MASK;
          state_d = S_CHECK;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      node_q  <= '0;
      waddr_q <= '0;
      left_q  <= '0;
      next_q  <= '0;
      data_q  <= '0;
      nodes_q <= '0;
    end else begin
      state_q <= state_d;
      node_q  <= node_d;
      waddr_q <= waddr_d;
      left_q  <= left_d;
      next_q  <= next_d;
      data_q  <= data_d;
      nodes_q <= nodes_d;
    end
  end

  p_out_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
  p_single_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  p_rvalid_expected_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rvalid_i |-> (state_q == S_HDR_WAIT || state_q == S_PAY_WAIT));
  p_req_aligned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));
  p_node_cap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nodes_q <= CW'(NODE_LIMIT));
  p_term_ptr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && done_cause_o == END_NORMAL) |-> done_ptr_o[TERM_BIT]);
endmodule

// File: rtl/llw_walker.sv
module llw_walker
  import llw_pkg::*;
#(
  parameter int AW         = 24,
  parameter int DW         = 32,
  parameter int MEM_AW     = 21,
  parameter int NODE_LIMIT = 2000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [31:0]       ctrl_wdata_i,
  input  logic              addr_wr_i,
  input  logic [AW-1:0]     addr_wdata_i,
  output logic [AW-1:0]     addr_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic [1:0]        end_cause_o,
  output logic              mem_req_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              out_valid_o,
  output logic [DW-1:0]     out_data_o,
  input  logic              out_ready_i
);
  logic [AW-1:0]     addr_q;
  logic              irq_q;
  end_cause_e        cause_q;
  logic              start;
  logic              busy;
  logic              done;
  end_cause_e        done_cause;
  logic [AW-1:0]     done_ptr;
  logic              g_hit, g_visit, g_clear;
  logic [MEM_AW-1:0] g_node;

  assign start = ctrl_wr_i && (ctrl_wdata_i == START_CODE) && !busy;

  llw_walk_fsm #(
    .AW(AW), .DW(DW), .MEM_AW(MEM_AW), .NODE_LIMIT(NODE_LIMIT)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .start_node_i (addr_q[MEM_AW-1:0]),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .out_valid_o  (out_valid_o),
    .out_data_o   (out_data_o),
    .out_ready_i  (out_ready_i),
    .guard_hit_i  (g_hit),
    .guard_visit_o(g_visit),
    .guard_clear_o(g_clear),
    .guard_node_o (g_node),
    .busy_o       (busy),
    .done_o       (done),
    .done_cause_o (done_cause),
    .done_ptr_o   (done_ptr)
  );

  llw_loop_guard #(.MEM_AW(MEM_AW)) u_guard (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(g_clear),
    .visit_i(g_visit),
    .node_i (g_node),
    .hit_o  (g_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      irq_q   <= 1'b0;
      cause_q <= END_NORMAL;
    end else begin
      irq_q <= done;
      if (done) begin
        addr_q  <= done_ptr;
        cause_q <= done_cause;
      end else if (addr_wr_i && !busy) begin
        addr_q <= addr_wdata_i;
      end
    end
  end

  assign addr_o      = addr_q;
  assign busy_o      = busy;
  assign irq_o       = irq_q;
  assign end_cause_o = cause_q;

  p_irq_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  p_irq_on_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> irq_o);
  p_irq_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !busy_o);
  p_addr_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(addr_o));
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !out_valid_o));
endmodule

// File: tb/tb_llw_walker.sv
`timescale 1ns/1ps
module tb_llw_walker;
  localparam int LIMIT = 6;
  localparam logic [31:0] GO = 32'h0100_0401;

  typedef struct packed {
    logic [23:0] start;
    logic [23:0] fin;
    logic [1:0]  cause;
    logic [7:0]  nwords;
    logic [31:0] sum;
  } vec_t;

  // start, final pointer, cause, payload words, payload sum
  localparam vec_t VECS [6] = '{
    '{24'h000100, 24'hFFFFFF, 2'd0, 8'd3, 32'hE0000350},  // R3 R5 R6 three nodes, middle empty
    '{24'h000200, 24'h800010, 2'd0, 8'd1, 32'hA0000204},  // R6 bit 23 only
    '{24'h000300, 24'h000300, 2'd1, 8'd2, 32'h40000618},  // R7 two-node ring
    '{24'h000040, 24'h000070, 2'd2, 8'd6, 32'hC0000210},  // R8 eight nodes, limit six
    '{24'hE00103, 24'hFFFFFF, 2'd0, 8'd3, 32'hE0000350},  // R2 start masked
    '{24'h000380, 24'h8ABCDE, 2'd0, 8'd2, 32'h40000718}   // R2 next masked
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_wr_i = 1'b0;
  logic [31:0] ctrl_wdata_i = '0;
  logic        addr_wr_i = 1'b0;
  logic [23:0] addr_wdata_i = '0;
  logic [23:0] addr_o;
  logic        busy_o, irq_o;
  logic [1:0]  end_cause_o;
  logic        mem_req_o;
  logic [20:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        out_valid_o;
  logic [31:0] out_data_o;
  logic        out_ready_i = 1'b1;

  llw_walker #(.NODE_LIMIT(LIMIT)) dut (.*);

  always #5 clk_i = ~clk_i;

  logic [31:0] mem [256];
  always @(posedge clk_i) begin
    mem_rvalid_i <= mem_req_o;
    mem_rdata_i  <= mem[mem_addr_o[9:2]];
  end

  int mon_cnt = 0;
  logic [31:0] mon_sum = '0;
  always @(posedge clk_i) if (out_valid_o && out_ready_i) begin
    mon_cnt <= mon_cnt + 1;
    mon_sum <= mon_sum + out_data_o;
  end

  int errors = 0, checks = 0, hold_viol = 0, ready_mode = 0;
  bit done_flag = 0;

  initial begin
    int ph = 0;
    forever begin
      @(posedge clk_i); #2;
      ph++;
      case (ready_mode)
        0: out_ready_i = 1'b1;
        1: out_ready_i = (ph % 3) != 0;
        default: out_ready_i = 1'b0;
      endcase
    end
  end

  // stream hold monitor, sampled at negedge
  initial begin
    logic pv, pr;
    logic [31:0] pd;
    pv = 0; pr = 0; pd = '0;
    forever begin
      @(negedge clk_i);
      if (rst_ni && pv && !pr && !(out_valid_o && out_data_o == pd)) hold_viol++;
      pv = out_valid_o; pr = out_ready_i; pd = out_data_o;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic write_addr(input logic [23:0] a);
    @(negedge clk_i); addr_wr_i = 1'b1; addr_wdata_i = a;
    @(negedge clk_i); addr_wr_i = 1'b0;
  endtask

  task automatic write_ctrl(input logic [31:0] v);
    @(negedge clk_i); ctrl_wr_i = 1'b1; ctrl_wdata_i = v;
    @(negedge clk_i); ctrl_wr_i = 1'b0;
  endtask

  task automatic wait_irq(output bit seen);
    seen = 0;
    for (int c = 0; c < 3000 && !seen; c++) begin
      if (irq_o) seen = 1;
      else @(negedge clk_i);
    end
  endtask

  task automatic run_vec(input int i);
    int bc;
    logic [31:0] bs;
    bit seen;
    write_addr(VECS[i].start);
    chk(addr_o == VECS[i].start, "R10 idle address load", addr_o, VECS[i].start);
    bc = mon_cnt; bs = mon_sum;
    write_ctrl(GO);
    wait_irq(seen);
    chk(seen, "R9 irq raised", 32'(seen), 32'd1);
    chk(!busy_o, "R9 busy low with irq", 32'(busy_o), 32'd0);
    chk(addr_o == VECS[i].fin, "R6 R7 R8 final pointer", addr_o, VECS[i].fin);
    chk(end_cause_o == VECS[i].cause, "R6 R7 R8 end cause", 32'(end_cause_o), 32'(VECS[i].cause));
    chk(mon_cnt - bc == int'(VECS[i].nwords), "R2 R3 R5 word count", 32'(mon_cnt - bc), 32'(VECS[i].nwords));
    chk(mon_sum - bs == VECS[i].sum, "R2 R4 payload sum", mon_sum - bs, VECS[i].sum);
    @(negedge clk_i);
    chk(!irq_o, "R9 irq one cycle", 32'(irq_o), 32'd0);
  endtask

  initial begin
    #(10ns * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    bit seen;
    int reqs;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem['h100>>2] = {8'd2, 24'h000120}; mem['h104>>2] = 32'hA0000104; mem['h108>>2] = 32'hA0000108;
    mem['h120>>2] = {8'd0, 24'h000140};
    mem['h140>>2] = {8'd1, 24'hFFFFFF}; mem['h144>>2] = 32'hA0000144;
    mem['h200>>2] = {8'd1, 24'h800010}; mem['h204>>2] = 32'hA0000204;
    mem['h300>>2] = {8'd1, 24'h000310}; mem['h304>>2] = 32'hA0000304;
    mem['h310>>2] = {8'd1, 24'h000300}; mem['h314>>2] = 32'hA0000314;
    mem['h380>>2] = {8'd1, 24'h600390}; mem['h384>>2] = 32'hA0000384;
    mem['h390>>2] = {8'd1, 24'h8ABCDE}; mem['h394>>2] = 32'hA0000394;
    for (int k = 0; k < 8; k++) begin
      mem[(8'h40 + 8*k) >> 2] = {8'd1, (k == 7) ? 24'hFFFFFF : 24'(24'h40 + 8*(k+1))};
      mem[(8'h44 + 8*k) >> 2] = 32'hA0000000 | 32'(8'h44 + 8*k);
    end

    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk(!busy_o && !irq_o, "R11 reset busy/irq", {busy_o, irq_o}, 0);
    chk(addr_o == 0 && end_cause_o == 0, "R11 reset addr/cause", {6'd0, end_cause_o, addr_o}, 0);
    chk(!mem_req_o && !out_valid_o, "R11 reset req/valid", {mem_req_o, out_valid_o}, 0);
    rst_ni = 1'b1;

    for (int i = 0; i < 6; i++) begin
      ready_mode = i % 2;
      run_vec(i);
    end

    // R1 wrong control code ignored
    write_addr(24'h000100);
    write_ctrl(32'h0100_0201);
    reqs = 0;
    for (int c = 0; c < 8; c++) begin
      if (busy_o || mem_req_o) reqs++;
      @(negedge clk_i);
    end
    chk(reqs == 0, "R1 other code ignored", reqs, 0);

    // R10 address write while busy ignored, R4 stall
    ready_mode = 2;
    write_addr(24'h000040);
    write_ctrl(GO);
    repeat (10) @(negedge clk_i);
    chk(busy_o && out_valid_o, "R4 stalled word held", {busy_o, out_valid_o}, 2'b11);
    chk(out_data_o == 32'hA0000044, "R4 first word", out_data_o, 32'hA0000044);
    write_addr(24'h123456);
    chk(addr_o == 24'h000040, "R10 busy write ignored", addr_o, 24'h000040);
    ready_mode = 0;
    wait_irq(seen);
    chk(seen && addr_o == 24'h000070, "R8 R10 final after busy write", addr_o, 24'h000070);
    chk(end_cause_o == 2'd2, "R8 limit cause", 32'(end_cause_o), 2);
    chk(hold_viol == 0, "R4 hold under backpressure", hold_viol, 0);
    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule